// File: doc/BRIEF.md
# Byte-to-Nibble Double-Rate Ethernet Transmit Converter

This block sits between a MAC that produces a byte-wide transmit stream and a reduced-pin transmit interface toward a PHY. The MAC side gives one byte per clock, with an enable bit and an error bit. The pin side has four data lines and one control line. Both pin-side outputs change on both edges of the transmit clock. The block also forwards the transmit clock to a pin. The clock is 125 MHz at 1000 Mb/s, 25 MHz at 100 Mb/s and 2.5 MHz at 10 Mb/s.

In gigabit mode a whole byte goes out in one clock cycle. The lower nibble is driven while the clock is high and the upper nibble while it is low. In the two slower modes a byte takes two cycles. Each of those cycles repeats one nibble in both halves, lower nibble first. The MAC must hold each byte for both cycles, because the block samples it only in the first one. The control line carries enable in the high half and error in the low half. A speed request is taken only at the start of a byte, and only while enable is low.

The double-rate output stage is generic RTL. Registered values are selected by the clock level, so no technology cell is needed.

Top module: `rgmii_tx_conv`

## Requirements
- R1: A synchronous active-high `rst` drives `txd_out` to 0 and `tx_ctl_out` to 0 in both clock halves of the following cycle.
- R2: In gigabit mode (`speed` bit 1 set, i.e. codes 2 and 3), the byte sampled at a rising edge appears in the cycle after that edge. Bits [3:0] appear on `txd_out` while `clk` is high, and bits [7:4] appear on `txd_out` while `clk` is low.
- R3: `tx_ctl_out` shows the sampled enable while `clk` is high and the sampled error while `clk` is low. In slow modes it keeps these values for both cycles of the byte.
- R4: In slow modes (code 0 for 10 Mb/s, code 1 for 100 Mb/s), a byte is sampled only in the first cycle of its two-cycle slot. The cycle after that edge shows bits [3:0] in both halves, and the next cycle shows bits [7:4] in both halves. Inputs in the second cycle of the slot have no effect.
- R5: When the sampled enable and error are both low, `txd_out` is 0 in both halves, whatever the data byte holds.
- R6: A new `speed` value is adopted only at a byte start edge where `tx_en` is low, and it governs the byte sampled at that same edge. At any other edge the speed input has no effect.
- R7: `txc_out` is high during the high half of `clk` and low during the low half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock, sourced on the MAC side |
| rst | input | 1 | Synchronous active-high reset |
| speed | input | 2 | Requested link speed: 0 = 10 Mb/s, 1 = 100 Mb/s, 2 or 3 = 1000 Mb/s |
| tx_data | input | 8 | Byte from the MAC |
| tx_en | input | 1 | Transmit enable from the MAC |
| tx_er | input | 1 | Transmit error from the MAC |
| txc_out | output | 1 | Forwarded transmit clock |
| txd_out | output | 4 | Double-rate data nibble |
| tx_ctl_out | output | 1 | Double-rate control: enable in the high half, error in the low half |

## Verification
Some properties are checked at every clock edge on the registered half-cycle values:
- the reset values;
- gigabit nibble placement against the byte of the previous cycle;
- slow-mode placement of both nibbles across their two cycles;
- idle zeroing;
- enable on the high control half;
- speed held steady while enable is high or mid-byte.

Some behaviour lives in the clock-level output selection, which only the bench's two samples per cycle can show:
- which value actually reaches each pin in each half;
- the forwarded clock;
- a speed switch landing at the correct byte start under random speed, enable, error and reset traffic.

// File: rtl/rgmii_tx_pkg.sv
package rgmii_tx_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;
  localparam int SPD_W  = 2;

  // speed code bit 1 set selects the one-cycle-per-byte mode
  function automatic logic is_gig(input logic [SPD_W-1:0] code);
    return code[1];
  endfunction

  // nibble of a byte after idle masking; upper selects bits [7:4]
  function automatic logic [NIB_W-1:0] pick_nib(input logic [BYTE_W-1:0] b,
                                                input logic upper,
                                                input logic en,
                                                input logic er);
    logic [NIB_W-1:0] n;
    n = upper ? b[BYTE_W-1:NIB_W] : b[NIB_W-1:0];
    return (en | er) ? n : '0;
  endfunction
endpackage

// File: rtl/rgmii_tx_rate_ctl.sv
module rgmii_tx_rate_ctl
  import rgmii_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SPD_W-1:0] speed_in,
  input  logic             tx_en,
  output logic             load,
  output logic             eff_gig,
  output logic [SPD_W-1:0] act_speed,
  output logic             second_half
);
  logic [SPD_W-1:0] eff_speed;

  // a byte starts on every edge in gigabit mode, every other edge otherwise
  assign load      = is_gig(act_speed) | ~second_half;
  assign eff_speed = (load & ~tx_en) ? speed_in : act_speed;
  assign eff_gig   = is_gig(eff_speed);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_speed   <= speed_in;
      second_half <= 1'b0;
    end else if (load) begin
      act_speed   <= eff_speed;
      second_half <= ~eff_gig;
    end else begin
      second_half <= 1'b0;
    end
  end
endmodule

// File: rtl/rgmii_tx_pack.sv
module rgmii_tx_pack
  import rgmii_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              eff_gig,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_en,
  input  logic              tx_er,
  output logic [NIB_W-1:0]  rise_nib,
  output logic [NIB_W-1:0]  fall_nib,
  output logic              ctl_rise,
  output logic              ctl_fall
);
  logic [NIB_W-1:0] held_hi;
  logic [NIB_W-1:0] lo_n, hi_n;

  assign lo_n = pick_nib(tx_data, 1'b0, tx_en, tx_er);
  assign hi_n = pick_nib(tx_data, 1'b1, tx_en, tx_er);

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_nib <= '0;
      fall_nib <= '0;
      ctl_rise <= 1'b0;
      ctl_fall <= 1'b0;
      held_hi  <= '0;
    end else if (load) begin
      ctl_rise <= tx_en;
      ctl_fall <= tx_er;
      rise_nib <= lo_n;
      fall_nib <= eff_gig ? hi_n : lo_n;
      held_hi  <= hi_n;
    end else begin
      rise_nib <= held_hi;
      fall_nib <= held_hi;
    end
  end
endmodule

// File: rtl/rgmii_tx_ddr_out.sv
module rgmii_tx_ddr_out #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic [W-1:0] rise_val,
  input  logic [W-1:0] fall_val,
  output logic [W-1:0] pin
);
  // high phase shows the value for the rising half, low phase the falling half
  assign pin = clk ? rise_val : fall_val;
endmodule

// File: rtl/rgmii_tx_conv.sv
module rgmii_tx_conv
  import rgmii_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [SPD_W-1:0]  speed,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_en,
  input  logic              tx_er,
  output logic              txc_out,
  output logic [NIB_W-1:0]  txd_out,
  output logic              tx_ctl_out
);
  logic             load;
  logic             eff_gig;
  logic [SPD_W-1:0] act_speed;
  logic             second_half;
  logic [NIB_W-1:0] rise_nib, fall_nib;
  logic             ctl_rise, ctl_fall;

  rgmii_tx_rate_ctl u_rate (
    .clk(clk), .rst(rst), .speed_in(speed), .tx_en(tx_en),
    .load(load), .eff_gig(eff_gig), .act_speed(act_speed),
    .second_half(second_half)
  );

  rgmii_tx_pack u_pack (
    .clk(clk), .rst(rst), .load(load), .eff_gig(eff_gig),
    .tx_data(tx_data), .tx_en(tx_en), .tx_er(tx_er),
    .rise_nib(rise_nib), .fall_nib(fall_nib),
    .ctl_rise(ctl_rise), .ctl_fall(ctl_fall)
  );

  rgmii_tx_ddr_out #(.W(NIB_W)) u_ddr_d (
    .clk(clk), .rise_val(rise_nib), .fall_val(fall_nib), .pin(txd_out)
  );

  rgmii_tx_ddr_out #(.W(1)) u_ddr_c (
    .clk(clk), .rise_val(ctl_rise), .fall_val(ctl_fall), .pin(tx_ctl_out)
  );

  rgmii_tx_ddr_out #(.W(1)) u_ddr_k (
    .clk(clk), .rise_val(1'b1), .fall_val(1'b0), .pin(txc_out)
  );
endmodule

// File: rtl/rgmii_tx_chk.sv
module rgmii_tx_chk
  import rgmii_tx_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [BYTE_W-1:0] tx_data,
  input logic              tx_en,
  input logic              tx_er,
  input logic              load,
  input logic [SPD_W-1:0]  act_speed,
  input logic              second_half,
  input logic [NIB_W-1:0]  rise_nib,
  input logic [NIB_W-1:0]  fall_nib,
  input logic              ctl_rise,
  input logic              ctl_fall
);
  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (rise_nib == '0 && fall_nib == '0 && !ctl_rise && !ctl_fall));

  // R2
  gig_place_chk: assert property (@(posedge clk) disable iff (rst)
    (load && act_speed[1] && tx_en) |=>
      (rise_nib == $past(tx_data[NIB_W-1:0]) && fall_nib == $past(tx_data[BYTE_W-1:NIB_W])));

  // R3
  ctl_en_chk: assert property (@(posedge clk) disable iff (rst)
    (load && tx_en) |=> ctl_rise);

  // R3
  ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    second_half |=> ($stable(ctl_rise) && $stable(ctl_fall)));

  // R4
  slow_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !act_speed[1] && tx_en) |=>
      (rise_nib == $past(tx_data[NIB_W-1:0]) && fall_nib == rise_nib));

  // R4
  slow_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !act_speed[1] && tx_en) |=> ##1
      (rise_nib == $past(tx_data[BYTE_W-1:NIB_W], 2) && fall_nib == rise_nib));

  // R5
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !tx_en && !tx_er) |=> (rise_nib == '0 && fall_nib == '0));

  // R6
  spd_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_en || second_half) |=> $stable(act_speed));
endmodule

bind rgmii_tx_conv rgmii_tx_chk u_chk (
  .clk(clk), .rst(rst), .tx_data(tx_data), .tx_en(tx_en), .tx_er(tx_er),
  .load(load), .act_speed(act_speed), .second_half(second_half),
  .rise_nib(rise_nib), .fall_nib(fall_nib),
  .ctl_rise(ctl_rise), .ctl_fall(ctl_fall)
);

// File: tb/rgmii_tx_conv_bench.sv
module rgmii_tx_conv_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] speed;
  logic [7:0] tx_data;
  logic       tx_en, tx_er;
  logic       txc_out;
  logic [3:0] txd_out;
  logic       tx_ctl_out;

  int vectors = 0;
  int errors  = 0;

  // reference state
  logic [1:0] m_spd;
  bit         m_mid;
  logic [3:0] m_up;
  logic [3:0] e_r, e_f;
  bit         e_cr, e_cf;
  string      d_tag;

  always #10 clk = ~clk;

  rgmii_tx_conv u_rgmii_tx_conv (
    .clk(clk), .rst(rst), .speed(speed), .tx_data(tx_data),
    .tx_en(tx_en), .tx_er(tx_er), .txc_out(txc_out),
    .txd_out(txd_out), .tx_ctl_out(tx_ctl_out)
  );

  function automatic logic [7:0] masked(logic [7:0] b, bit en, bit er);
    return (en || er) ? b : 8'h00;
  endfunction

  // predicts the half-cycle outputs produced by the coming rising edge
  task automatic predict();
    if (rst) begin
      {e_r, e_f, e_cr, e_cf} = '0;
      m_spd = speed; m_mid = 0; d_tag = "R1";
    end else if (m_mid == 0 || m_spd >= 2) begin
      logic [7:0] b;
      logic [1:0] s;
      s = tx_en ? m_spd : speed;
      b = masked(tx_data, tx_en, tx_er);
      e_cr = tx_en; e_cf = tx_er;
      e_r = b[3:0];
      if (s >= 2) begin e_f = b[7:4]; m_mid = 0; d_tag = "R2"; end
      else begin e_f = b[3:0]; m_up = b[7:4]; m_mid = 1; d_tag = "R4"; end
      if (!tx_en && !tx_er) d_tag = "R5";
      m_spd = s;
    end else begin
      e_r = m_up; e_f = m_up; m_mid = 0; d_tag = "R4";
    end
  endtask

  task automatic cmp(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic tick(string over = "");
    string dt, ct;
    predict();
    dt = (over != "") ? over : d_tag;
    ct = rst ? "R1" : "R3";
    @(posedge clk);
    #5;
    cmp(dt, txd_out, e_r); cmp(ct, tx_ctl_out, e_cr); cmp("R7", txc_out, 1);
    #10;
    cmp(dt, txd_out, e_f); cmp(ct, tx_ctl_out, e_cf); cmp("R7", txc_out, 0);
  endtask

  task automatic put(logic [7:0] d, bit en, bit er);
    tx_data = d; tx_en = en; tx_er = er;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; speed = 2'd2; put(8'hFF, 1, 1);
    tick(); tick();                       // R1 reset values
    rst = 0;
    put(8'hA5, 1, 0); tick();             // R2 R3
    put(8'h3C, 1, 1); tick();             // R3 error half
    put(8'hFF, 0, 0); tick();             // R5 data ignored when idle
    put(8'h0F, 0, 1); tick();             // error only still carries data
    speed = 2'd0;
    put(8'h96, 1, 0); tick("R6");         // R6 speed ignored while enabled
    put(8'h69, 1, 0); tick("R6");
    put(8'h00, 0, 0); tick("R6");         // switch to 10 Mb/s here
    tick();
    put(8'h5A, 1, 0); tick(); tick();     // R4 low then high nibble
    put(8'hC3, 1, 1); tick(); put(8'h11, 0, 0); tick(); // R4 second cycle ignored
    put(8'h00, 0, 0); tick();
    speed = 2'd1; tick("R6");             // mid-byte: not yet adopted
    tick("R6");
    speed = 2'd2; put(8'h00, 0, 0); tick(); tick();
    put(8'hE7, 1, 0); tick();
    for (int i = 0; i < 4000; i++) begin
      rst = ($urandom_range(0, 299) == 0);
      if ($urandom_range(0, 19) == 0) speed = 2'($urandom_range(0, 3));
      put(8'($urandom), $urandom_range(0, 3) != 0, $urandom_range(0, 7) == 0);
      tick();
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule